// File: doc/BRIEF.md
# Glitch-Free Delay-Line Phase Stepper

This block moves the sampling clock of a delay-locked loop to a new output phase (one of sixteen) without producing a runt pulse on that clock. A single-cycle start request carries a 4-bit phase index. The block then runs a fixed series of read-modify-write updates on the loop's 32-bit configuration word. First it parks the clock output and hands phase selection to an external select field. It then programs that field with the Gray-coded index and re-enables the clock output. Finally it returns control to the loop's own recovery logic.

Between updates, the block waits for the loop to confirm that its clock output has actually stopped or restarted. It samples a status input once per microsecond and allows at most fifty samples per wait. The microsecond pacing comes from a prescaler derived from the system clock frequency parameter. When the sequence finishes, the block gives a one-cycle completion pulse. When a wait runs out, the block stops at once, sets a sticky error flag and writes nothing more. The choice of which phase to request is left to the caller.

Top module: `dllph_seq`

## Requirements
- R1: After reset, busy, done and error are low and no configuration write is issued.
- R2: In the first cycle after an accepted start, one write clears bits 17 (recovery enable) and 18 (clock-output enable), sets bits 16 (loop enable) and 19 (external select enable), and keeps all other bits of the current word.
- R3: The block then waits for the status input to read 0. Samples are taken every CLK_HZ/1e6 cycles, and the first sample is taken one such interval after the wait begins. The block continues as soon as a sample matches.
- R4: The next write places the reflected Gray code of the phase index (index XOR index>>1) into bits 23:20 and keeps all other bits.
- R5: In the following cycle, a write sets bit 18 and keeps the other bits. The block then waits for the status input to read 1, with the same sampling rules as R3.
- R6: The last write sets bit 17, clears bit 19 and keeps the other bits. The cycle after it, done pulses high for exactly one cycle, and busy falls after that pulse.
- R7: If a wait sees fifty samples that do not match, the block returns to idle and sets the error flag. It issues no further writes. The error flag stays high until the next accepted start clears it.
- R8: A start request that arrives while busy is ignored. The phase of the running sequence is not changed.
- R9: Busy is high from the first write through the done cycle, and a write is only ever issued while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| phase_i | input | 4 | Requested phase index 0..15 |
| cfg_rdata_i | input | 32 | Current value of the loop configuration word |
| ckout_sts_i | input | 1 | Clock-output enable as reported back by the loop |
| cfg_we_o | output | 1 | Configuration write strobe |
| cfg_wdata_o | output | 32 | Configuration word to write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Sticky timeout error |

## Verification
The bound checker verifies on every cycle that writes happen only while busy and that the first write of a sequence has the right enable bits. It also checks that the phase latch cannot change mid-sequence, that done is a single pulse following a write that enables recovery, and that an error leaves the block idle and silent. Only the bench scenarios can show the rest: the exact microsecond sampling instants, the fifty-sample limit at both waits, the Gray value in bits 23:20 for every index, and that bits outside the touched fields are preserved. For these, a behavioural model of the sequence and of the loop's delayed acknowledge is compared against the outputs on every clock.

// File: rtl/dllph_pkg.sv
package dllph_pkg;
  localparam int CFG_W       = 32;
  localparam int LOOP_EN_BIT = 16;
  localparam int RECOV_BIT   = 17;
  localparam int CKOUT_BIT   = 18;
  localparam int EXTSEL_BIT  = 19;
  localparam int SEL_LSB     = 20;
  localparam int SEL_W       = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PARK  = 3'd1,
    ST_WOFF  = 3'd2,
    ST_SEL   = 3'd3,
    ST_ARM   = 3'd4,
    ST_WON   = 3'd5,
    ST_REL   = 3'd6,
    ST_FIN   = 3'd7
  } seq_state_e;

  function automatic logic [SEL_W-1:0] to_gray(input logic [SEL_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/dllph_tick.sv
module dllph_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap   = (cnt_q == LAST);
      assign tick_o = run_i && wrap;

      always_comb begin
        cnt_d = cnt_q;
        if (!run_i)     cnt_d = '0;
        else if (wrap)  cnt_d = '0;
        else            cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate
endmodule

// File: rtl/dllph_poll.sv
module dllph_poll #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic sts_i,
  input  logic target_i,
  output logic match_o,
  output logic expire_o
);
  localparam int NW = $clog2(LIMIT + 1);
  localparam logic [NW-1:0] LAST = NW'(LIMIT - 1);

  logic [NW-1:0] miss_q, miss_d;
  logic          hit;

  assign hit      = (sts_i == target_i);
  assign match_o  = run_i && tick_i && hit;
  assign expire_o = run_i && tick_i && !hit && (miss_q == LAST);

  always_comb begin
    miss_d = miss_q;
    if (!run_i)             miss_d = '0;
    else if (tick_i && !hit) miss_d = miss_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= '0;
    else        miss_q <= miss_d;
  end
endmodule

// File: rtl/dllph_rmw.sv
module dllph_rmw
  import dllph_pkg::*;
(
  input  seq_state_e        state_i,
  input  logic [CFG_W-1:0]  rdata_i,
  input  logic [SEL_W-1:0]  phase_i,
  output logic              we_o,
  output logic [CFG_W-1:0]  wdata_o
);
  logic [SEL_W-1:0] code;
  logic [CFG_W-1:0] sel_word;

  assign code = to_gray(phase_i);

  genvar g;
  generate
    for (g = 0; g < CFG_W; g++) begin : g_bit
      if (g >= SEL_LSB && g < SEL_LSB + SEL_W) begin : g_fld
        assign sel_word[g] = code[g - SEL_LSB];
      end else begin : g_keep
        assign sel_word[g] = rdata_i[g];
      end
    end
  endgenerate

  always_comb begin
    we_o    = 1'b0;
    wdata_o = rdata_i;
    unique case (state_i)
      ST_PARK: begin
        we_o    = 1'b1;
        wdata_o = rdata_i;
        wdata_o[RECOV_BIT]   = 1'b0;
        wdata_o[CKOUT_BIT]   = 1'b0;
        wdata_o[LOOP_EN_BIT] = 1'b1;
        wdata_o[EXTSEL_BIT]  = 1'b1;
      end
      ST_SEL: begin
        we_o    = 1'b1;
        wdata_o = sel_word;
      end
      ST_ARM: begin
        we_o    = 1'b1;
        wdata_o = rdata_i;
        wdata_o[CKOUT_BIT] = 1'b1;
      end
      ST_REL: begin
        we_o    = 1'b1;
        wdata_o = rdata_i;
        wdata_o[RECOV_BIT]  = 1'b1;
        wdata_o[EXTSEL_BIT] = 1'b0;
      end
      default: begin
        we_o    = 1'b0;
        wdata_o = rdata_i;
      end
    endcase
  end
endmodule

// File: rtl/dllph_seq.sv
module dllph_seq
  import dllph_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int POLL_LIMIT = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [3:0]  phase_i,
  input  logic [31:0] cfg_rdata_i,
  input  logic        ckout_sts_i,
  output logic        cfg_we_o,
  output logic [31:0] cfg_wdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int TICK_DIV = CLK_HZ / 1_000_000;

  seq_state_e       state_q, state_d;
  logic [SEL_W-1:0] phase_q, phase_d;
  logic             err_q, err_d;
  logic             waiting, want_on, tick, match, expire, accept;

  assign waiting = (state_q == ST_WOFF) || (state_q == ST_WON);
  assign want_on = (state_q == ST_WON);
  assign accept  = (state_q == ST_IDLE) && start_i;

  dllph_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (waiting),
    .tick_o (tick)
  );

  dllph_poll #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (waiting),
    .tick_i   (tick),
    .sts_i    (ckout_sts_i),
    .target_i (want_on),
    .match_o  (match),
    .expire_o (expire)
  );

  dllph_rmw u_rmw (
    .state_i (state_q),
    .rdata_i (cfg_rdata_i),
    .phase_i (phase_q),
    .we_o    (cfg_we_o),
    .wdata_o (cfg_wdata_o)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_PARK;
        phase_d = phase_i;
        err_d   = 1'b0;
      end
      ST_PARK: state_d = ST_WOFF;
      ST_WOFF: begin
        if (match)       state_d = ST_SEL;
        else if (expire) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_SEL:  state_d = ST_ARM;
      ST_ARM:  state_d = ST_WON;
      ST_WON: begin
        if (match)       state_d = ST_REL;
        else if (expire) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_REL:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) phase_q <= phase_d;
      err_q   <= err_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
  assign err_o  = err_q;
endmodule

// File: rtl/dllph_seq_chk.sv
module dllph_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        cfg_we_o,
  input logic [31:0] cfg_wdata_o,
  input logic [3:0]  phase_q
);
  // R9
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_o |-> busy_o);

  // R2
  park_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (cfg_we_o && cfg_wdata_o[16] && cfg_wdata_o[19]
                       && !cfg_wdata_o[17] && !cfg_wdata_o[18]));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  // R6
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(cfg_we_o) && $past(cfg_wdata_o[17]) && !$past(cfg_wdata_o[19])));

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!busy_o && !cfg_we_o && !done_o));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !busy_o && !start_i) |=> !cfg_we_o);

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(phase_q));
endmodule

bind dllph_seq dllph_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .cfg_we_o    (cfg_we_o),
  .cfg_wdata_o (cfg_wdata_o),
  .phase_q     (phase_q)
);

// File: tb/dllph_seq_test.sv
module dllph_seq_test;
  localparam int PERIOD = 10;
  localparam int HZ     = 4_000_000;
  localparam int DIV    = HZ / 1_000_000;
  localparam int LIM    = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [3:0] phase_i = '0;
  logic [31:0] cfg;
  logic sts;
  logic cfg_we_o, busy_o, done_o, err_o;
  logic [31:0] cfg_wdata_o;

  // loop model controls
  logic        load = 1'b0;
  logic [31:0] cfg_init = '0;
  logic        sts_init = 1'b0;
  logic        stuck = 1'b0;
  integer      ack_dly = 2;
  integer      acnt, wr_cnt;
  logic        saw_done;

  integer tests = 0, fails = 0, cyc_tests = 0, cyc_fails = 0;
  logic main_done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dllph_seq #(.CLK_HZ(HZ), .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
    .cfg_rdata_i(cfg), .ckout_sts_i(sts), .cfg_we_o(cfg_we_o),
    .cfg_wdata_o(cfg_wdata_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  // behavioural loop: register plus delayed acknowledge of bit 18
  always @(posedge clk) begin
    if (load) begin
      cfg <= cfg_init; sts <= sts_init; acnt <= 0; wr_cnt <= 0; saw_done <= 1'b0;
    end else begin
      if (cfg_we_o) begin cfg <= cfg_wdata_o; wr_cnt <= wr_cnt + 1; end
      if (done_o) saw_done <= 1'b1;
      if (!stuck) begin
        if (sts != cfg[18]) begin
          if (acnt >= ack_dly) begin sts <= cfg[18]; acnt <= 0; end
          else acnt <= acnt + 1;
        end else acnt <= 0;
      end
    end
  end

  // reference sequence model
  integer m_st, m_wc;
  logic [3:0] m_ph;
  logic m_err;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_wc <= 0; m_ph <= '0; m_err <= 1'b0;
    end else begin
      case (m_st)
        0: if (start_i) begin m_st <= 1; m_ph <= phase_i; m_err <= 1'b0; end
        1: begin m_st <= 2; m_wc <= 0; end
        2, 5: begin
          m_wc <= m_wc + 1;
          if (m_wc % DIV == DIV - 1) begin
            if (sts == (m_st == 5)) m_st <= (m_st == 2) ? 3 : 6;
            else if (m_wc / DIV + 1 == LIM) begin m_st <= 0; m_err <= 1'b1; end
          end
        end
        3: m_st <= 4;
        4: begin m_st <= 5; m_wc <= 0; end
        6: m_st <= 7;
        default: m_st <= 0;
      endcase
    end
  end

  function automatic [3:0] gry(input [3:0] p);
    return p ^ (p >> 1);
  endfunction

  function automatic string stage_req(input integer s);
    case (s)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      default: return "R9";
    endcase
  endfunction

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !load) begin
      logic [31:0] ew;
      logic        ewe;
      ewe = (m_st == 1 || m_st == 3 || m_st == 4 || m_st == 6);
      ew  = cfg;
      case (m_st)
        1: ew = (cfg & ~32'h0006_0000) | 32'h0009_0000;
        3: ew = (cfg & ~32'h00F0_0000) | (32'(gry(m_ph)) << 20);
        4: ew = cfg | 32'h0004_0000;
        6: ew = (cfg | 32'h0002_0000) & ~32'h0008_0000;
        default: ew = cfg;
      endcase
      cyc_tests = cyc_tests + 1;
      if (cfg_we_o !== ewe || busy_o !== (m_st != 0) || done_o !== (m_st == 7)
          || (ewe && cfg_wdata_o !== ew)) begin
        cyc_fails = cyc_fails + 1;
        $display("FAIL %s stage %0d: we=%b busy=%b done=%b wdata=%h exp we=%b busy=%b done=%b wdata=%h",
                 stage_req(m_st), m_st, cfg_we_o, busy_o, done_o, cfg_wdata_o,
                 ewe, (m_st != 0), (m_st == 7), ew);
      end
      cyc_tests = cyc_tests + 1;
      if (err_o !== m_err) begin
        cyc_fails = cyc_fails + 1;
        $display("FAIL R7 err flag: act=%b exp=%b", err_o, m_err);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] init, input logic s0, input bit stk, input integer dly);
    @(negedge clk);
    cfg_init = init; sts_init = s0; stuck = stk; ack_dly = dly; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_seq(input logic [3:0] ph);
    integer guard;
    @(negedge clk);
    start_i = 1'b1; phase_i = ph;
    @(negedge clk);
    start_i = 1'b0;
    guard = 0;
    while (busy_o && guard < 20000) begin @(negedge clk); guard = guard + 1; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    setup(32'h8A3C_5E71, 1'b1, 1'b0, 2);
    chk(!busy_o && !done_o && !err_o && !cfg_we_o, "R1", {28'd0, busy_o, done_o, err_o, cfg_we_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !cfg_we_o, "R1", {30'd0, busy_o, cfg_we_o}, 32'd0);

    // nominal sequence, phase 5
    run_seq(4'd5);
    chk(saw_done && !err_o, "R6", {30'd0, saw_done, err_o}, 32'd2);
    chk(wr_cnt == 4, "R9", wr_cnt, 32'd4);
    chk(cfg[23:20] == gry(4'd5), "R4", cfg[23:20], gry(4'd5));
    chk(cfg[19:16] == 4'b0111, "R6", cfg[19:16], 32'h7);
    chk({cfg[31:24], cfg[15:0]} == {8'h8A, 16'h5E71}, "R2", {cfg[31:24], cfg[15:0]}, {8'h8A, 16'h5E71});

    // every phase index, varying acknowledge delay
    for (int p = 0; p < 16; p++) begin
      setup(32'h0000_0000 | (32'(p) << 8), 1'b0, 1'b0, p % 7);
      run_seq(p[3:0]);
      chk(cfg[23:20] == gry(p[3:0]), "R4", cfg[23:20], gry(p[3:0]));
      chk(saw_done, "R3", saw_done, 1);
    end

    // start while busy is ignored
    setup(32'h1234_0000, 1'b1, 1'b0, 9);
    @(negedge clk); start_i = 1'b1; phase_i = 4'd9;
    @(negedge clk); phase_i = 4'd2;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    chk(cfg[23:20] == gry(4'd9), "R8", cfg[23:20], gry(4'd9));
    chk(wr_cnt == 4, "R8", wr_cnt, 32'd4);

    // first wait never satisfied
    setup(32'hFFFF_FFFF, 1'b1, 1'b1, 0);
    run_seq(4'd3);
    chk(err_o && !busy_o && !saw_done, "R7", {29'd0, err_o, busy_o, saw_done}, 32'd4);
    chk(wr_cnt == 1, "R7", wr_cnt, 32'd1);
    repeat (20) @(negedge clk);
    chk(wr_cnt == 1 && err_o, "R7", wr_cnt, 32'd1);

    // second wait never satisfied
    setup(32'h0000_0000, 1'b0, 1'b1, 0);
    run_seq(4'd12);
    chk(err_o && wr_cnt == 3, "R7", wr_cnt, 32'd3);
    chk(cfg[23:20] == gry(4'd12), "R4", cfg[23:20], gry(4'd12));

    // slow but in-limit acknowledge clears the error
    setup(32'h0F0F_0F0F, 1'b1, 1'b0, 40 * DIV);
    run_seq(4'd15);
    chk(!err_o && saw_done, "R3", {30'd0, err_o, saw_done}, 32'd1);
    chk(cfg[23:20] == gry(4'd15), "R5", cfg[23:20], gry(4'd15));

    // acknowledge beyond the limit
    setup(32'h0000_0000, 1'b0, 1'b0, 60 * DIV);
    run_seq(4'd6);
    chk(err_o && wr_cnt == 3, "R5", wr_cnt, 32'd3);

    repeat (4) @(negedge clk);
    main_done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests + cyc_tests, fails + cyc_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!main_done) begin
      $display("FAIL watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests + cyc_tests + 1, fails + cyc_fails + 1);
      $finish;
    end
  end
endmodule